// File: doc/BRIEF.md
# Embedded Processor Boot Release Sequencer

This block sits on the host side of a device whose embedded microprocessor cannot run until its memories have been filled. On a start pulse it reads the device's firmware identification register. If that register is nonzero, firmware is already running and the sequencer finishes at once without touching the device. Otherwise it halts the processor, asks an external loader to fill data memory and then instruction memory, and clears the soft-reset and low-power bits of the system control register. It then holds the processor in reset for a timed minimum and finally lets it run.

Register traffic uses a simple request/acknowledge port with one access outstanding at a time. Memory fills use a separate request/done handshake toward a loader that is outside this block. The block reports the outcome as a one-cycle success or failure pulse.

Top module: `boot_release_seq`

## Requirements
- R1: After reset, reg_req, ld_req, done and err are all low.
- R2: A start pulse in idle makes the first register access a read (reg_we low) of address 0x0020, the firmware identification register (major version in bits 15:8, minor in bits 7:0).
- R3: If the identification value is nonzero in either byte, the sequencer pulses done once and makes no register write and no load request.
- R4: If the identification value is zero, the next access writes 0x0041 to control address 0xC001, which sets run-stall (bit 0) and stall-override (bit 6).
- R5: After the stall write, a load is requested for data memory (ld_sel 0, ld_base 0x3FFE0000) and, after it completes, one for instruction memory (ld_sel 1, ld_base 0x40000000). A register request and a load request are never raised together.
- R6: A load that completes with ld_err high pulses err once, gives no done, and is followed by no further register access or load request.
- R7: After both loads succeed, address 0x0000 is read and written back with bits 15 and 11 cleared and every other bit unchanged.
- R8: The next access writes 0x8041 to 0xC001: stall, override and processor reset (bit 15) together.
- R9: The release write follows the reset write by at least CLK_MHZ*HOLD_US clock cycles, and by no more than three cycles beyond that.
- R10: The last access writes 0x0040 to 0xC001 (override only), after which done pulses for exactly one cycle.
- R11: A start pulse while a sequence is running has no effect on the access or load order.
- R12: An outstanding register or load request keeps its direction, address, data, select and base stable until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a boot sequence (ignored while running) |
| reg_req | output | 1 | Register access request, held until reg_ack |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 16 | Register address |
| reg_wdata | output | 16 | Write data |
| reg_ack | input | 1 | Access complete; reg_rdata valid in this cycle |
| reg_rdata | input | 16 | Read data |
| ld_req | output | 1 | Memory fill request, held until ld_done |
| ld_sel | output | 1 | 0 = data memory, 1 = instruction memory |
| ld_base | output | LOAD_AW | Target base address of the fill |
| ld_done | input | 1 | Fill finished |
| ld_err | input | 1 | Fill failed, qualified by ld_done |
| done | output | 1 | One-cycle pulse: sequence completed or skipped |
| err | output | 1 | One-cycle pulse: sequence aborted by a failed fill |

## Verification
The bench sweeps identification values with only the major byte, only the minor byte, or neither set, a range of system control patterns, and a failure on each of the two fills. A design that tested only one byte of the identification would reload running firmware; one that wrote a constant instead of a masked read-back would disturb unrelated control bits; one that skipped the abort would go on to release a half-loaded processor. The reset-to-release gap is measured in cycles against the computed hold, so a timer that is off by a large amount or that is bypassed shows up, as do stray start pulses injected while a sequence runs.

// File: rtl/boot_seq_pkg.sv
`timescale 1ns/1ps
package boot_seq_pkg;
  localparam int REG_W = 16;

  localparam logic [REG_W-1:0] A_FWID   = 16'h0020;
  localparam logic [REG_W-1:0] A_CTRL   = 16'hC001;
  localparam logic [REG_W-1:0] A_SYSCTL = 16'h0000;

  localparam int B_STALL = 0;
  localparam int B_OVR   = 6;
  localparam int B_URST  = 15;
  localparam int B_SRST  = 15;
  localparam int B_LPWR  = 11;

  localparam logic [REG_W-1:0] V_STALL   = (16'h1 << B_STALL) | (16'h1 << B_OVR);
  localparam logic [REG_W-1:0] V_RESET   = V_STALL | (16'h1 << B_URST);
  localparam logic [REG_W-1:0] V_RELEASE = 16'h1 << B_OVR;
  localparam logic [REG_W-1:0] M_SYSCLR  = (16'h1 << B_SRST) | (16'h1 << B_LPWR);

  typedef enum logic [3:0] {
    S_IDLE, S_ID, S_STALL, S_LD_D, S_LD_I,
    S_SC_RD, S_SC_WR, S_RST, S_HOLD, S_REL
  } seq_state_t;
endpackage

// File: rtl/boot_hold_timer.sv
`timescale 1ns/1ps
module boot_hold_timer #(
  parameter int HOLD_CYCLES = 20000
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic expired
);
  localparam int HC = (HOLD_CYCLES < 1) ? 1 : HOLD_CYCLES;
  localparam int CW = $clog2(HC + 1);
  localparam logic [CW-1:0] LOAD_V = CW'(HC - 1);

  logic [CW-1:0] cnt;
  logic          active;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (arm) begin
      cnt    <= LOAD_V;
      active <= 1'b1;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign expired = active && (cnt == '0);

  // R9: the count walks down one per cycle while armed
  p_count_down_r9: assert property (@(posedge clk) disable iff (rst)
    (active && cnt != '0 && !arm) |=> (active && cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/boot_load_port.sv
`timescale 1ns/1ps
module boot_load_port #(
  parameter int          LOAD_AW   = 32,
  parameter logic [31:0] DMEM_BASE = 32'h3FFE_0000,
  parameter logic [31:0] IMEM_BASE = 32'h4000_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic               go_sel,
  input  logic               ld_done,
  input  logic               ld_err,
  output logic               ld_req,
  output logic               ld_sel,
  output logic [LOAD_AW-1:0] ld_base,
  output logic               fin_ok,
  output logic               fin_bad
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ld_req  <= 1'b0;
      ld_sel  <= 1'b0;
      ld_base <= '0;
    end else if (go) begin
      ld_req  <= 1'b1;
      ld_sel  <= go_sel;
      ld_base <= go_sel ? LOAD_AW'(IMEM_BASE) : LOAD_AW'(DMEM_BASE);
    end else if (ld_req && ld_done) begin
      ld_req <= 1'b0;
    end
  end

  assign fin_ok  = ld_req && ld_done && !ld_err;
  assign fin_bad = ld_req && ld_done && ld_err;

  // R12: a pending fill request keeps its target steady
  p_ld_stable_r12: assert property (@(posedge clk) disable iff (rst)
    (ld_req && !ld_done) |=> (ld_req && $stable(ld_sel) && $stable(ld_base)));
endmodule

// File: rtl/boot_release_seq.sv
`timescale 1ns/1ps
module boot_release_seq
  import boot_seq_pkg::*;
#(
  parameter int          CLK_MHZ   = 200,
  parameter int          HOLD_US   = 100,
  parameter int          LOAD_AW   = 32,
  parameter logic [31:0] DMEM_BASE = 32'h3FFE_0000,
  parameter logic [31:0] IMEM_BASE = 32'h4000_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  output logic               reg_req,
  output logic               reg_we,
  output logic [15:0]        reg_addr,
  output logic [15:0]        reg_wdata,
  input  logic               reg_ack,
  input  logic [15:0]        reg_rdata,
  output logic               ld_req,
  output logic               ld_sel,
  output logic [LOAD_AW-1:0] ld_base,
  input  logic               ld_done,
  input  logic               ld_err,
  output logic               done,
  output logic               err
);
  localparam int HOLD_CYCLES = CLK_MHZ * HOLD_US;

  seq_state_t       state;
  logic [REG_W-1:0] sc_q;

  logic             acc_en, acc_we;
  logic [REG_W-1:0] acc_addr, acc_data;
  logic             acc_fin;
  logic             ld_go, ld_go_sel, fin_ok, fin_bad;
  logic             tmr_arm, tmr_expired;

  // access each register state wants to issue
  always_comb begin
    acc_en   = 1'b1;
    acc_we   = 1'b1;
    acc_addr = A_CTRL;
    acc_data = '0;
    unique case (state)
      S_ID:    begin acc_we = 1'b0; acc_addr = A_FWID; end
      S_STALL: acc_data = V_STALL;
      S_SC_RD: begin acc_we = 1'b0; acc_addr = A_SYSCTL; end
      S_SC_WR: begin acc_addr = A_SYSCTL; acc_data = sc_q & ~M_SYSCLR; end
      S_RST:   acc_data = V_RESET;
      S_REL:   acc_data = V_RELEASE;
      default: acc_en = 1'b0;
    endcase
  end

  assign acc_fin   = acc_en && reg_req && reg_ack;
  assign ld_go     = (state == S_LD_D || state == S_LD_I) && !ld_req;
  assign ld_go_sel = (state == S_LD_I);
  assign tmr_arm   = (state == S_RST) && acc_fin;

  boot_load_port #(
    .LOAD_AW(LOAD_AW), .DMEM_BASE(DMEM_BASE), .IMEM_BASE(IMEM_BASE)
  ) u_load (
    .clk(clk), .rst(rst), .go(ld_go), .go_sel(ld_go_sel),
    .ld_done(ld_done), .ld_err(ld_err),
    .ld_req(ld_req), .ld_sel(ld_sel), .ld_base(ld_base),
    .fin_ok(fin_ok), .fin_bad(fin_bad)
  );

  boot_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk(clk), .rst(rst), .arm(tmr_arm), .expired(tmr_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      reg_req   <= 1'b0;
      reg_we    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      sc_q      <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (acc_en && !reg_req) begin
        reg_req   <= 1'b1;
        reg_we    <= acc_we;
        reg_addr  <= acc_addr;
        reg_wdata <= acc_data;
      end else if (acc_fin) begin
        reg_req <= 1'b0;
      end
      unique case (state)
        S_IDLE:  if (start) state <= S_ID;
        S_ID:    if (acc_fin) begin
                   if (reg_rdata != '0) begin
                     done  <= 1'b1;
                     state <= S_IDLE;
                   end else begin
                     state <= S_STALL;
                   end
                 end
        S_STALL: if (acc_fin) state <= S_LD_D;
        S_LD_D, S_LD_I: begin
                 if (fin_bad) begin
                   err   <= 1'b1;
                   state <= S_IDLE;
                 end else if (fin_ok) begin
                   state <= (state == S_LD_D) ? S_LD_I : S_SC_RD;
                 end
               end
        S_SC_RD: if (acc_fin) begin
                   sc_q  <= reg_rdata;
                   state <= S_SC_WR;
                 end
        S_SC_WR: if (acc_fin) state <= S_RST;
        S_RST:   if (acc_fin) state <= S_HOLD;
        S_HOLD:  if (tmr_expired) state <= S_REL;
        S_REL:   if (acc_fin) begin
                   done  <= 1'b1;
                   state <= S_IDLE;
                 end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R12: a pending register access holds its fields
  p_req_stable_r12: assert property (@(posedge clk) disable iff (rst)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_we) && $stable(reg_addr) && $stable(reg_wdata)));
  // R5: never both handshakes at once
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (rst)
    !(reg_req && ld_req));
  // R10: done is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R6: err is a single-cycle pulse and never with done
  p_err_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    err |=> (!err && !done));
  // R9: hold state is left only once the timer has run out
  p_hold_wait_r9: assert property (@(posedge clk) disable iff (rst)
    (state == S_HOLD && !tmr_expired) |=> (state == S_HOLD));
  // R11: start has no effect while a sequence is running
  p_start_ignored_r11: assert property (@(posedge clk) disable iff (rst)
    (state == S_HOLD && start && !tmr_expired) |=> (state == S_HOLD));
endmodule

// File: tb/boot_release_seq_tb.sv
`timescale 1ns/1ps
module boot_release_seq_tb;
  localparam int CLK_MHZ = 1;
  localparam int HOLD_US = 6;
  localparam int HOLD    = CLK_MHZ * HOLD_US;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic reg_req, reg_we, reg_ack;
  logic [15:0] reg_addr, reg_wdata, reg_rdata;
  logic ld_req, ld_sel, ld_done, ld_err;
  logic [31:0] ld_base;
  logic done, err;

  always #2.5 clk = ~clk;

  boot_release_seq #(.CLK_MHZ(CLK_MHZ), .HOLD_US(HOLD_US)) u_dut (
    .clk(clk), .rst(rst), .start(start),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .reg_rdata(reg_rdata),
    .ld_req(ld_req), .ld_sel(ld_sel), .ld_base(ld_base),
    .ld_done(ld_done), .ld_err(ld_err), .done(done), .err(err)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  logic [15:0] id_val, sc_val;
  logic fail_d, fail_i;

  logic        lg_we   [16];
  logic [15:0] lg_addr [16];
  logic [15:0] lg_data [16];
  int          n_lg;
  logic        ld_lg_sel  [4];
  logic [31:0] ld_lg_base [4];
  int          n_ld;
  int          done_cnt, err_cnt, t_rst, t_rel;
  logic        overlap;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // register and loader responders
  initial begin
    logic prev_ack, prev_ld;
    int   ld_wait;
    prev_ack = 0; prev_ld = 0; ld_wait = 0;
    reg_ack = 0; reg_rdata = '0; ld_done = 0; ld_err = 0;
    forever begin
      @(negedge clk);
      reg_ack = 0; ld_done = 0; ld_err = 0;
      if (reg_req && ld_req) overlap = 1;
      if (done) done_cnt++;
      if (err) err_cnt++;
      if (reg_req && !prev_ack) begin
        reg_ack   = 1;
        reg_rdata = (reg_addr == 16'h0020) ? id_val : (reg_addr == 16'h0000) ? sc_val : 16'h0;
        if (n_lg < 16) begin
          lg_we[n_lg]   = reg_we;
          lg_addr[n_lg] = reg_addr;
          lg_data[n_lg] = reg_we ? reg_wdata : reg_rdata;
        end
        n_lg++;
        if (reg_we && reg_addr == 16'hC001 && reg_wdata == 16'h8041) t_rst = cyc;
        if (reg_we && reg_addr == 16'hC001 && reg_wdata == 16'h0040) t_rel = cyc;
      end
      if (ld_req && !prev_ld) begin
        if (ld_wait == 2) begin
          ld_done = 1;
          ld_err  = ld_sel ? fail_i : fail_d;
          if (n_ld < 4) begin
            ld_lg_sel[n_ld]  = ld_sel;
            ld_lg_base[n_ld] = ld_base;
          end
          n_ld++;
          ld_wait = 0;
        end else begin
          ld_wait++;
        end
      end
      prev_ack = reg_ack;
      prev_ld  = ld_done;
    end
  end

  task automatic expect_acc(input int i, input logic we, input logic [15:0] a,
                            input logic [15:0] d, input string tag);
    chk(i < n_lg && lg_we[i] == we && lg_addr[i] == a && lg_data[i] == d, tag,
        (i < n_lg) ? {lg_we[i], lg_addr[i], lg_data[i]} : -1, {we, a, d});
  endtask

  task automatic run_case(input logic [15:0] id, input logic [15:0] sc,
                          input logic fd, input logic fi, input logic extra);
    logic skip;
    int   exp_n, exp_ld, waited;
    id_val = id; sc_val = sc; fail_d = fd; fail_i = fi;
    n_lg = 0; n_ld = 0; done_cnt = 0; err_cnt = 0; t_rst = 0; t_rel = 0; overlap = 0;
    skip = (id != 0);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    waited = 0;
    while (done_cnt + err_cnt == 0 && waited < 2000) begin
      if (extra && (waited == 3 || waited == 20)) start = 1; else start = 0;
      @(negedge clk);
      waited++;
    end
    start = 0;
    if (waited >= 2000) chk(0, "watchdog case timeout", waited, 0);
    repeat (6) @(negedge clk);

    exp_n  = skip ? 1 : (fd || fi) ? 2 : 6;
    exp_ld = skip ? 0 : fd ? 1 : 2;
    // R2 first access is a read of the id register
    expect_acc(0, 1'b0, 16'h0020, id, "R2 id read");
    chk(n_lg == exp_n, "R3/R6 access count", n_lg, exp_n);
    chk(n_ld == exp_ld, "R3/R6 load count", n_ld, exp_ld);
    chk(!overlap, "R5 request overlap", overlap, 0);
    if (!skip) expect_acc(1, 1'b1, 16'hC001, 16'h0041, "R4 stall write");
    if (exp_ld >= 1) chk(ld_lg_sel[0] == 0 && ld_lg_base[0] == 32'h3FFE0000,
                         "R5 data load first", ld_lg_base[0], 32'h3FFE0000);
    if (exp_ld >= 2) chk(ld_lg_sel[1] == 1 && ld_lg_base[1] == 32'h40000000,
                         "R5 instr load second", ld_lg_base[1], 32'h40000000);
    if (fd || fi) begin
      if (!skip) begin
        chk(err_cnt == 1, "R6 err pulse", err_cnt, 1);
        chk(done_cnt == 0, "R6 no done", done_cnt, 0);
      end
    end
    if (skip || (!fd && !fi)) begin
      chk(done_cnt == 1, "R3/R10 done pulse", done_cnt, 1);
      chk(err_cnt == 0, "R10 no err", err_cnt, 0);
    end
    if (!skip && !fd && !fi) begin
      expect_acc(2, 1'b0, 16'h0000, sc, "R7 sysctl read");
      expect_acc(3, 1'b1, 16'h0000, sc & 16'h77FF, "R7 sysctl masked write");
      expect_acc(4, 1'b1, 16'hC001, 16'h8041, "R8 reset write");
      expect_acc(5, 1'b1, 16'hC001, 16'h0040, "R10 release write");
      chk((t_rel - t_rst) >= HOLD && (t_rel - t_rst) <= HOLD + 3,
          "R9 hold gap", t_rel - t_rst, HOLD + 2);
    end
  endtask

  initial begin
    id_val = 0; sc_val = 0; fail_d = 0; fail_i = 0;
    n_lg = 0; n_ld = 0; done_cnt = 0; err_cnt = 0; overlap = 0; t_rst = 0; t_rel = 0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!reg_req && !ld_req && !done && !err, "R1 reset outputs",
        {reg_req, ld_req, done, err}, 0);
    rst = 0;
    @(negedge clk);
    // R3 skip with major-only and minor-only id
    run_case(16'h0100, 16'hFFFF, 0, 0, 0);
    run_case(16'h0001, 16'hFFFF, 0, 0, 0);
    // R7 sweep of sysctl patterns through the full sequence
    for (int k = 0; k < 8; k++)
      run_case(16'h0000, 16'(16'h1357 * k) ^ 16'h8800, 0, 0, 0);
    run_case(16'h0000, 16'hFFFF, 0, 0, 0);
    // R6 failures on each fill
    run_case(16'h0000, 16'hFFFF, 1, 0, 0);
    run_case(16'h0000, 16'hFFFF, 0, 1, 0);
    // R11 stray starts mid-sequence
    run_case(16'h0000, 16'h8801, 0, 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule